// File: doc/BRIEF.md
# Ring Queue Pointer Controller

This block holds a bank of hardware ring queues for a producer/consumer pair that share descriptor rings in memory. Every queue owns a free-running read pointer and a free-running write pointer. Software never loads a pointer directly: it advances one by writing a small increment into a per-queue add register, and it reads the current pointer values back from status registers. A consumer turns a pointer into a ring slot by masking it with the ring size minus one, so every ring size is a power of two.

Registers are reached over a flat 32-bit bus. The address is split into a queue index (the bits above bit 10) and an offset inside a 2 KiB window. Each queue also carries a size exponent and a set of sticky error flags. An increment that is too large, one that would overfill the ring, or one that would move the read pointer past the write pointer is refused, and the pointer stays where it was.

Top module: `qpc_top`

## Requirements
- R1: Queue n is decoded from address bits 18:11 (window base n × 0x800). A queue index at or above NUM_QUEUES is ignored on writes and reads as zero.
- R2: A write to offset 0x0 adds wdata to that queue's read pointer. A write to offset 0x4 adds wdata to its write pointer.
- R3: A read of offset 0x8 returns the read pointer in bits 17:0. A read of offset 0xC returns the write pointer in bits 17:0. Bits 31:18 of every read are zero, and reads of offsets 0x0 and 0x4 return zero.
- R4: An add write whose value exceeds 0x3F leaves both pointers unchanged and sets flag bit 0.
- R5: Pointers are 18 bits wide and wrap modulo 2^18 when an increment is added.
- R6: A write-pointer add that would make (wptr − rptr) mod 2^18 exceed 2^size leaves the pointer unchanged and sets flag bit 1.
- R7: A read-pointer add larger than (wptr − rptr) mod 2^18 leaves the pointer unchanged and sets flag bit 2.
- R8: Offset 0x10 holds the size exponent (ring of 2^size entries, 0 to 17), read back in bits 4:0. A write of a value above 17 is ignored.
- R9: Offset 0x14 reads the flags (bit 0 oversize add, bit 1 overflow, bit 2 underflow). Writing ones clears the matching bits, and writing zeros leaves them set.
- R10: Synchronous reset clears every pointer and flag, and sets every size exponent to 17.
- R11: rvalid rises in the cycle after rd_en and carries the data. A read issued in the cycle after an add returns the updated pointer.
- R12: Writes to the status offsets 0x8 and 0xC and to any undefined offset change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address within the queue area |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |

## Verification
The hardest state to reach is pointer wrap at 2^18. Increments are capped at 0x3F and the ring may never hold more than 2^17 entries, so the wrap needs thousands of interleaved write-pointer and read-pointer adds that keep the occupancy small until both pointers cross zero. The overflow and underflow boundaries are reached by shrinking one ring to four entries and probing exactly one increment past full and past empty. A behavioural model of every queue predicts each read value and the rvalid line on every clock.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int OFF_W = 11;

  localparam logic [OFF_W-1:0] OFS_ADD_RD = 11'h000;
  localparam logic [OFF_W-1:0] OFS_ADD_WR = 11'h004;
  localparam logic [OFF_W-1:0] OFS_STS_RD = 11'h008;
  localparam logic [OFF_W-1:0] OFS_STS_WR = 11'h00C;
  localparam logic [OFF_W-1:0] OFS_SIZE   = 11'h010;
  localparam logic [OFF_W-1:0] OFS_FLAGS  = 11'h014;

  localparam int FLG_W   = 3;
  localparam int FLG_BIG = 0;
  localparam int FLG_OVF = 1;
  localparam int FLG_UNF = 2;

  typedef enum logic [2:0] {
    SEL_ADD_RD,
    SEL_ADD_WR,
    SEL_STS_RD,
    SEL_STS_WR,
    SEL_SIZE,
    SEL_FLAGS,
    SEL_NONE
  } qsel_e;
endpackage

// File: rtl/qpc_decode.sv
module qpc_decode
  import qpc_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int NUM_QUEUES = 16,
  parameter int QIDX_W     = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [QIDX_W-1:0] qidx,
  output logic              hit,
  output qsel_e             sel
);
  localparam int QFIELD_W = ADDR_W - OFF_W;

  logic [QFIELD_W-1:0] qfield;
  logic [OFF_W-1:0]    offset;

  assign qfield = addr[ADDR_W-1:OFF_W];
  assign offset = addr[OFF_W-1:0];
  assign hit    = 32'(qfield) < NUM_QUEUES;
  assign qidx   = qfield[QIDX_W-1:0];

  always_comb begin
    case (offset)
      OFS_ADD_RD: sel = SEL_ADD_RD;
      OFS_ADD_WR: sel = SEL_ADD_WR;
      OFS_STS_RD: sel = SEL_STS_RD;
      OFS_STS_WR: sel = SEL_STS_WR;
      OFS_SIZE:   sel = SEL_SIZE;
      OFS_FLAGS:  sel = SEL_FLAGS;
      default:    sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/qpc_step.sv
module qpc_step
  import qpc_pkg::*;
#(
  parameter int PTR_W   = 18,
  parameter int SZ_W    = 5,
  parameter int MAX_ADD = 63
) (
  input  logic             we,
  input  qsel_e            sel,
  input  logic [31:0]      wdata,
  input  logic [PTR_W-1:0] rptr_i,
  input  logic [PTR_W-1:0] wptr_i,
  input  logic [SZ_W-1:0]  szlog_i,
  input  logic [FLG_W-1:0] flags_i,
  output logic [PTR_W-1:0] rptr_o,
  output logic [PTR_W-1:0] wptr_o,
  output logic [SZ_W-1:0]  szlog_o,
  output logic [FLG_W-1:0] flags_o
);
  localparam int MAX_SZLOG = PTR_W - 1;

  logic [PTR_W-1:0] inc;
  logic [PTR_W-1:0] occ;
  logic [PTR_W:0]   cap;
  logic [PTR_W:0]   fill_sum;
  logic             big;
  logic             ovf;
  logic             unf;

  assign inc      = wdata[PTR_W-1:0];
  assign big      = wdata > 32'(MAX_ADD);
  assign occ      = wptr_i - rptr_i;
  assign cap      = (PTR_W+1)'(1) << szlog_i;
  assign fill_sum = {1'b0, occ} + {1'b0, inc};
  assign ovf      = fill_sum > cap;
  assign unf      = inc > occ;

  always_comb begin
    rptr_o  = rptr_i;
    wptr_o  = wptr_i;
    szlog_o = szlog_i;
    flags_o = flags_i;
    if (we) begin
      case (sel)
        SEL_ADD_RD: begin
          if (big)      flags_o[FLG_BIG] = 1'b1;
          else if (unf) flags_o[FLG_UNF] = 1'b1;
          else          rptr_o = rptr_i + inc;
        end
        SEL_ADD_WR: begin
          if (big)      flags_o[FLG_BIG] = 1'b1;
          else if (ovf) flags_o[FLG_OVF] = 1'b1;
          else          wptr_o = wptr_i + inc;
        end
        SEL_SIZE: begin
          if (wdata <= 32'(MAX_SZLOG)) szlog_o = wdata[SZ_W-1:0];
        end
        SEL_FLAGS: flags_o = flags_i & ~wdata[FLG_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/qpc_rdback.sv
module qpc_rdback
  import qpc_pkg::*;
#(
  parameter int PTR_W = 18,
  parameter int SZ_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             hit,
  input  qsel_e            sel,
  input  logic [PTR_W-1:0] rptr,
  input  logic [PTR_W-1:0] wptr,
  input  logic [SZ_W-1:0]  szlog,
  input  logic [FLG_W-1:0] flags,
  output logic [31:0]      rdata,
  output logic             rvalid
);
  logic [31:0] value;

  always_comb begin
    value = '0;
    if (hit) begin
      case (sel)
        SEL_STS_RD: value = 32'(rptr);
        SEL_STS_WR: value = 32'(wptr);
        SEL_SIZE:   value = 32'(szlog);
        SEL_FLAGS:  value = 32'(flags);
        default:    value = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= value;
    end
  end
endmodule

// File: rtl/qpc_top.sv
module qpc_top
  import qpc_pkg::*;
#(
  parameter int NUM_QUEUES = 16,
  parameter int ADDR_W     = 19,
  parameter int PTR_W      = 18,
  parameter int MAX_ADD    = 63
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid
);
  localparam int QIDX_W    = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1;
  localparam int SZ_W      = $clog2(PTR_W);
  localparam int MAX_SZLOG = PTR_W - 1;

  logic [PTR_W-1:0] rptr_q  [NUM_QUEUES];
  logic [PTR_W-1:0] wptr_q  [NUM_QUEUES];
  logic [SZ_W-1:0]  szlog_q [NUM_QUEUES];
  logic [FLG_W-1:0] flags_q [NUM_QUEUES];

  logic [QIDX_W-1:0] qidx;
  logic              hit;
  qsel_e             sel;

  logic [PTR_W-1:0] cur_r, cur_w, nxt_r, nxt_w;
  logic [SZ_W-1:0]  cur_s, nxt_s;
  logic [FLG_W-1:0] cur_f, nxt_f;

  qpc_decode #(
    .ADDR_W(ADDR_W), .NUM_QUEUES(NUM_QUEUES), .QIDX_W(QIDX_W)
  ) u_decode (
    .addr(addr), .qidx(qidx), .hit(hit), .sel(sel)
  );

  assign cur_r = rptr_q[qidx];
  assign cur_w = wptr_q[qidx];
  assign cur_s = szlog_q[qidx];
  assign cur_f = flags_q[qidx];

  qpc_step #(
    .PTR_W(PTR_W), .SZ_W(SZ_W), .MAX_ADD(MAX_ADD)
  ) u_step (
    .we(wr_en && hit), .sel(sel), .wdata(wdata),
    .rptr_i(cur_r), .wptr_i(cur_w), .szlog_i(cur_s), .flags_i(cur_f),
    .rptr_o(nxt_r), .wptr_o(nxt_w), .szlog_o(nxt_s), .flags_o(nxt_f)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_QUEUES; i++) begin
        rptr_q[i]  <= '0;
        wptr_q[i]  <= '0;
        szlog_q[i] <= SZ_W'(MAX_SZLOG);
        flags_q[i] <= '0;
      end
    end else if (wr_en && hit) begin
      rptr_q[qidx]  <= nxt_r;
      wptr_q[qidx]  <= nxt_w;
      szlog_q[qidx] <= nxt_s;
      flags_q[qidx] <= nxt_f;
    end
  end

  qpc_rdback #(
    .PTR_W(PTR_W), .SZ_W(SZ_W)
  ) u_rdback (
    .clk(clk), .rst(rst), .rd_en(rd_en), .hit(hit), .sel(sel),
    .rptr(cur_r), .wptr(cur_w), .szlog(cur_s), .flags(cur_f),
    .rdata(rdata), .rvalid(rvalid)
  );

  // R11: a read request is answered in the next cycle
  a_r11_read_valid: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);

  // R11: no read data appears without a request
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(rd_en));

  // R3: unused upper read bits stay zero
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> (rdata[31:PTR_W] == '0));

  // R4: an oversize add raises the sticky error bit
  a_r4_big_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit && (sel == SEL_ADD_RD || sel == SEL_ADD_WR) && wdata > 32'(MAX_ADD))
    |=> flags_q[$past(qidx)][FLG_BIG]);

  // R6: after a write-pointer add the ring is within size or overflow is flagged
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit && sel == SEL_ADD_WR)
    |=> (({1'b0, (wptr_q[$past(qidx)] - rptr_q[$past(qidx)])}
          <= ((PTR_W+1)'(1) << szlog_q[$past(qidx)]))
         || flags_q[$past(qidx)][FLG_OVF]));
endmodule

// File: tb/qpc_top_tb_top.sv
`timescale 1ns/1ps
module qpc_top_tb_top;
  localparam int NQ     = 16;
  localparam int ADDR_W = 19;
  localparam int PTRM   = 1 << 18;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              rvalid;

  int tests = 0;
  int fails = 0;
  logic exp_rv = 1'b0;

  int mr [NQ];
  int mw [NQ];
  int ms [NQ];
  int mf [NQ];

  qpc_top #(.NUM_QUEUES(NQ), .ADDR_W(ADDR_W), .PTR_W(18), .MAX_ADD(63)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  always #4 clk = ~clk;

  function automatic void model_reset();
    for (int i = 0; i < NQ; i++) begin
      mr[i] = 0; mw[i] = 0; ms[i] = 17; mf[i] = 0;
    end
  endfunction

  function automatic void model_write(int q, int off, int val);
    int occ;
    if (q >= NQ) return;
    occ = (mw[q] - mr[q] + PTRM) % PTRM;
    case (off)
      'h0: if (val > 63) mf[q] |= 1;
           else if (val > occ) mf[q] |= 4;
           else mr[q] = (mr[q] + val) % PTRM;
      'h4: if (val > 63) mf[q] |= 1;
           else if (occ + val > (1 << ms[q])) mf[q] |= 2;
           else mw[q] = (mw[q] + val) % PTRM;
      'h10: if (val <= 17) ms[q] = val;
      'h14: mf[q] = mf[q] & ~val & 7;
      default: ;
    endcase
  endfunction

  function automatic int model_read(int q, int off);
    if (q >= NQ) return 0;
    case (off)
      'h8:  return mr[q];
      'hC:  return mw[q];
      'h10: return ms[q];
      'h14: return mf[q];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) exp_rv <= rst ? 1'b0 : rd_en;

  // R11: rvalid compared against the model on every clock
  always @(negedge clk) begin
    if (!rst) begin
      tests++;
      if (rvalid !== exp_rv) begin
        fails++;
        $display("FAIL R11 rvalid actual=%0b expected=%0b", rvalid, exp_rv);
      end
    end
  end

  task automatic bus_wr(int q, int off, int val);
    model_write(q, off, val);
    @(negedge clk);
    wr_en = 1'b1;
    addr  = ADDR_W'(q * 2048 + off);
    wdata = 32'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(int q, int off, string tag);
    int exp;
    exp = model_read(q, off);
    @(negedge clk);
    rd_en = 1'b1;
    addr  = ADDR_W'(q * 2048 + off);
    @(negedge clk);
    rd_en = 1'b0;
    tests++;
    if (rvalid !== 1'b1 || rdata !== 32'(exp)) begin
      fails++;
      $display("FAIL %s q=%0d off=0x%0h actual=0x%0h expected=0x%0h",
               tag, q, off, rdata, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    // R10: reset state
    bus_rd(0, 'h8, "R10");
    bus_rd(0, 'hC, "R10");
    bus_rd(0, 'h14, "R10");
    bus_rd(7, 'h10, "R10");
    // R2 / R11: adds, read right after the add
    bus_wr(1, 'h4, 5);
    bus_rd(1, 'hC, "R2");
    bus_wr(1, 'h0, 3);
    bus_rd(1, 'h8, "R2");
    // R3: add registers read zero
    bus_rd(1, 'h0, "R3");
    bus_rd(1, 'h4, "R3");
    // R1: neighbour untouched, last queue works, out-of-range ignored
    bus_rd(2, 'hC, "R1");
    bus_wr(15, 'h4, 9);
    bus_rd(15, 'hC, "R1");
    bus_wr(20, 'h4, 7);
    bus_rd(20, 'hC, "R1");
    bus_rd(4, 'hC, "R1");
    // R4: oversize add refused
    bus_wr(1, 'h4, 64);
    bus_rd(1, 'hC, "R4");
    bus_rd(1, 'h14, "R4");
    bus_wr(1, 'h0, 100);
    bus_rd(1, 'h8, "R4");
    // R9: clear by writing ones, zeros keep
    bus_wr(1, 'h14, 0);
    bus_rd(1, 'h14, "R9");
    bus_wr(1, 'h14, 1);
    bus_rd(1, 'h14, "R9");
    // R12: status and undefined writes ignored
    bus_wr(1, 'h8, 7);
    bus_wr(1, 'hC, 7);
    bus_wr(1, 'h40, 7);
    bus_rd(1, 'h8, "R12");
    bus_rd(1, 'hC, "R12");
    bus_rd(1, 'h14, "R12");
    // R8: size register, invalid value ignored
    bus_wr(3, 'h10, 2);
    bus_rd(3, 'h10, "R8");
    bus_wr(3, 'h10, 18);
    bus_rd(3, 'h10, "R8");
    // R6: fill a 4-entry ring, then one past full
    bus_wr(3, 'h4, 4);
    bus_rd(3, 'hC, "R6");
    bus_wr(3, 'h4, 1);
    bus_rd(3, 'hC, "R6");
    bus_rd(3, 'h14, "R6");
    // R7: one past empty, then drain exactly
    bus_wr(3, 'h0, 5);
    bus_rd(3, 'h8, "R7");
    bus_rd(3, 'h14, "R7");
    bus_wr(3, 'h0, 4);
    bus_rd(3, 'h8, "R7");
    // R5: wrap both pointers through 2^18
    for (int i = 0; i < 4161; i++) begin
      bus_wr(5, 'h4, 63);
      bus_wr(5, 'h0, 63);
    end
    bus_rd(5, 'hC, "R5");
    bus_wr(5, 'h4, 2);
    bus_wr(5, 'h0, 2);
    bus_rd(5, 'hC, "R5");
    bus_rd(5, 'h8, "R5");
    bus_rd(5, 'h14, "R5");
    // R10: reset in mid-run
    do_reset();
    bus_rd(5, 'h8, "R10");
    bus_rd(3, 'h10, "R10");
    bus_rd(3, 'h14, "R10");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule